// File: doc/BRIEF.md
# Split-Completion Reorder Buffer

This block sits behind the receive side of a bus endpoint and in front of a consumer that expects read data in the order the reads were issued. Each outgoing read asks the block for a tag. The block hands out tags in rising order and remembers that order. Read data then comes back as completion beats, and each beat carries the tag of the read it answers. A single read may be answered by several short completions, and the pieces of different reads may arrive interleaved. The pieces of any one read still arrive in their own order.

Every tag owns a private buffer, so an arriving beat is appended to the buffer named by its tag. A beat flagged as last marks that buffer complete. An output stream with valid/ready handshaking drains whole reads, one at a time. It always drains the oldest outstanding tag, and only once that tag is complete. A tag goes back to the free pool after its final word has left the output. Beats that cannot be stored are discarded, and they set a sticky error flag.

Top module: `cpl_reorder_buf`

## Requirements
- R1: Tags are handed out as 0,1,2,...,7 and then wrap to 0. `req_tag` shows the tag that the next accepted request (`req_valid` and `req_ready` high at a clock edge) will take. It advances by one after each accepted request.
- R2: `req_ready` is low while all eight tags are outstanding. It returns high once the oldest tag has been fully drained.
- R3: The beats of one read are stored in arrival order and appended behind each other. The output presents that read's words in the same order.
- R4: When completions for several outstanding reads interleave, the output presents every word of the earliest-issued read before any word of a later one.
- R5: Output of a tag begins only when that tag is both complete and the oldest outstanding tag. A complete younger tag waits behind an incomplete older one.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_last` hold their values.
- R7: `out_last` is high on the final word of each read and low on every other word. This holds for reads of 1 and of 16 words.
- R8: A beat whose tag is not outstanding is discarded and sets `err_flag` one cycle later. `err_flag` stays high until reset.
- R9: A beat is discarded and sets `err_flag` if its buffer already holds 16 words, or if its tag has already received its last beat.
- R10: After reset all tags are free, `req_tag` is 0, `req_ready` is 1, `out_valid` is 0 and `err_flag` is 0.
- R11: If the output is idle and the beat that completes the oldest tag is accepted at edge E, the first word of that tag is valid after edge E+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A read wants a tag |
| req_ready | output | 1 | A tag is free |
| req_tag | output | 3 | Tag the next accepted read receives |
| cpl_valid | input | 1 | Completion beat present |
| cpl_tag | input | 3 | Tag carried by the beat |
| cpl_data | input | 32 | Beat data word |
| cpl_last | input | 1 | Final beat of this tag's read |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Consumer takes the word |
| out_data | output | 32 | Output data word |
| out_last | output | 1 | Final word of the current read |
| err_flag | output | 1 | Sticky discarded-beat flag |

## Verification
`req_tag` and `req_ready` change at the edge that accepts a request. `err_flag` rises at the edge that sees a discarded beat. The first word of a tag appears one edge after the edge that completed it, and each later word follows one edge after a handshake, with a one-cycle gap between reads. All stimulus changes on the falling clock edge and every output is sampled there, so each check reads a value that has been settled for half a period. The ordering checks compare each handshaken word against a queue the bench filled in issue order. Those checks are therefore free of any cycle count. The directed checks for latency and error timing sample at the exact falling edge the cycle count above predicts.

// File: rtl/cpl_rob_pkg.sv
package cpl_rob_pkg;
  typedef enum logic [0:0] {
    DRN_IDLE = 1'b0,
    DRN_SEND = 1'b1
  } drain_state_e;
endpackage

// File: rtl/rob_tag_ring.sv
module rob_tag_ring #(
  parameter int TAG_W = 3,
  localparam int NTAGS = 1 << TAG_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  output logic [TAG_W-1:0] req_tag,
  input  logic             free_en,
  output logic [TAG_W-1:0] head_tag,
  output logic [NTAGS-1:0] busy
);
  logic [TAG_W-1:0] next_q, head_q;
  logic [NTAGS-1:0] busy_q, busy_d;
  logic             take;

  // tags are allocated in order, so the pool is full exactly when the next one is busy
  assign req_ready = ~busy_q[next_q];
  assign take      = req_valid & req_ready;
  assign req_tag   = next_q;
  assign head_tag  = head_q;
  assign busy      = busy_q;

  always_comb begin
    busy_d = busy_q;
    if (take)    busy_d[next_q] = 1'b1;
    if (free_en) busy_d[head_q] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= '0;
      next_q <= '0;
      head_q <= '0;
    end else begin
      busy_q <= busy_d;
      if (take)    next_q <= next_q + 1'b1;
      if (free_en) head_q <= head_q + 1'b1;
    end
  end

  AST_FULL_STALL: assert property (@(posedge clk) disable iff (rst)
    (&busy_q) |-> !req_ready); // R2
  AST_TAG_STEP: assert property (@(posedge clk) disable iff (rst)
    take |=> (req_tag == $past(req_tag) + 1'b1)); // R1
  AST_FREE_BUSY: assert property (@(posedge clk) disable iff (rst)
    free_en |-> busy_q[head_q]); // R5
endmodule

// File: rtl/rob_beat_store.sv
module rob_beat_store #(
  parameter int TAG_W  = 3,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  localparam int NTAGS = 1 << TAG_W,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = IDX_W + 1,
  localparam int ADR_W = TAG_W + IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpl_valid,
  input  logic [TAG_W-1:0]  cpl_tag,
  input  logic [DATA_W-1:0] cpl_data,
  input  logic              cpl_last,
  input  logic [NTAGS-1:0]  busy,
  input  logic [TAG_W-1:0]  head_tag,
  input  logic              clear_en,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_q,
  output logic [CNT_W-1:0]  head_len,
  output logic              head_done,
  output logic              err_flag
);
  logic [DATA_W-1:0] mem [NTAGS*DEPTH];
  logic [CNT_W-1:0]  cnt_q [NTAGS];
  logic [NTAGS-1:0]  done_q;
  logic              err_q;
  logic              wr_ok;
  logic [IDX_W-1:0]  wr_idx;
  logic [ADR_W-1:0]  wr_adr, rd_adr;

  assign wr_idx    = cnt_q[cpl_tag][IDX_W-1:0];
  assign wr_ok     = cpl_valid && busy[cpl_tag] && !done_q[cpl_tag]
                     && (cnt_q[cpl_tag] != CNT_W'(DEPTH));
  assign wr_adr    = {cpl_tag, wr_idx};
  assign rd_adr    = {head_tag, rd_idx};
  assign head_len  = cnt_q[head_tag];
  assign head_done = done_q[head_tag];
  assign err_flag  = err_q;

  // data array: no reset, one write port, one registered read port
  always_ff @(posedge clk) begin
    if (wr_ok) mem[wr_adr] <= cpl_data;
    if (rd_en) rd_q <= mem[rd_adr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done_q <= '0;
      err_q  <= 1'b0;
      for (int t = 0; t < NTAGS; t++) cnt_q[t] <= '0;
    end else begin
      if (cpl_valid && !wr_ok) err_q <= 1'b1;
      for (int t = 0; t < NTAGS; t++) begin
        if (clear_en && (head_tag == TAG_W'(t))) begin
          cnt_q[t]  <= '0;
          done_q[t] <= 1'b0;
        end else if (wr_ok && (cpl_tag == TAG_W'(t))) begin
          cnt_q[t]  <= cnt_q[t] + 1'b1;
          done_q[t] <= cpl_last;
        end
      end
    end
  end

  for (genvar g = 0; g < NTAGS; g++) begin : g_tag_chk
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
      cnt_q[g] <= CNT_W'(DEPTH)); // R9
    AST_DONE_HAS_DATA: assert property (@(posedge clk) disable iff (rst)
      done_q[g] |-> (cnt_q[g] != '0)); // R3
  end

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    err_q |=> err_q); // R8
  AST_DROP_FREE_TAG: assert property (@(posedge clk) disable iff (rst)
    (cpl_valid && !busy[cpl_tag]) |=> err_q); // R8
endmodule

// File: rtl/rob_drain_fsm.sv
module rob_drain_fsm
  import cpl_rob_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             head_busy,
  input  logic             head_done,
  input  logic [CNT_W-1:0] head_len,
  input  logic             out_ready,
  output logic             rd_en,
  output logic [IDX_W-1:0] rd_idx,
  output logic             free_en,
  output logic             out_valid,
  output logic             out_last
);
  drain_state_e     st_q;
  logic [IDX_W-1:0] idx_q;
  logic             vld_q, last_q, start, fire;

  assign start     = (st_q == DRN_IDLE) && head_busy && head_done;
  assign fire      = vld_q && out_ready;
  assign out_valid = vld_q;
  assign out_last  = last_q;

  always_comb begin
    rd_en   = 1'b0;
    rd_idx  = '0;
    free_en = 1'b0;
    if (start) begin
      rd_en = 1'b1;
    end else if ((st_q == DRN_SEND) && fire) begin
      if (last_q) begin
        free_en = 1'b1;
      end else begin
        rd_en  = 1'b1;
        rd_idx = idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= DRN_IDLE;
      idx_q  <= '0;
      vld_q  <= 1'b0;
      last_q <= 1'b0;
    end else begin
      case (st_q)
        DRN_IDLE: if (start) begin
          st_q   <= DRN_SEND;
          idx_q  <= '0;
          vld_q  <= 1'b1;
          last_q <= (head_len == CNT_W'(1));
        end
        DRN_SEND: if (fire) begin
          if (last_q) begin
            st_q   <= DRN_IDLE;
            vld_q  <= 1'b0;
            last_q <= 1'b0;
          end else begin
            idx_q  <= idx_q + 1'b1;
            last_q <= ((CNT_W'(idx_q) + CNT_W'(2)) == head_len);
          end
        end
        default: st_q <= DRN_IDLE;
      endcase
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (vld_q && !out_ready) |=> (vld_q && $stable(last_q))); // R6
endmodule

// File: rtl/cpl_reorder_buf.sv
module cpl_reorder_buf #(
  parameter int TAG_W  = 3,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  localparam int NTAGS = 1 << TAG_W,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  output logic [TAG_W-1:0]  req_tag,
  input  logic              cpl_valid,
  input  logic [TAG_W-1:0]  cpl_tag,
  input  logic [DATA_W-1:0] cpl_data,
  input  logic              cpl_last,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_last,
  output logic              err_flag
);
  logic [NTAGS-1:0] busy;
  logic [TAG_W-1:0] head_tag;
  logic             free_en, rd_en, head_done;
  logic [IDX_W-1:0] rd_idx;
  logic [CNT_W-1:0] head_len;

  rob_tag_ring #(.TAG_W(TAG_W)) ring_i (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_tag(req_tag),
    .free_en(free_en), .head_tag(head_tag), .busy(busy)
  );

  rob_beat_store #(.TAG_W(TAG_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) store_i (
    .clk(clk), .rst(rst),
    .cpl_valid(cpl_valid), .cpl_tag(cpl_tag), .cpl_data(cpl_data), .cpl_last(cpl_last),
    .busy(busy), .head_tag(head_tag), .clear_en(free_en),
    .rd_en(rd_en), .rd_idx(rd_idx), .rd_q(out_data),
    .head_len(head_len), .head_done(head_done), .err_flag(err_flag)
  );

  rob_drain_fsm #(.DEPTH(DEPTH)) drain_i (
    .clk(clk), .rst(rst),
    .head_busy(busy[head_tag]), .head_done(head_done), .head_len(head_len),
    .out_ready(out_ready), .rd_en(rd_en), .rd_idx(rd_idx), .free_en(free_en),
    .out_valid(out_valid), .out_last(out_last)
  );

  AST_DRAIN_GATED: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (busy[head_tag] && head_done)); // R5
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> $stable(out_data)); // R6
endmodule

// File: tb/cpl_reorder_buf_tb.sv
module cpl_reorder_buf_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_ready;
  logic [2:0]  req_tag;
  logic        cpl_valid = 1'b0, cpl_last = 1'b0;
  logic [2:0]  cpl_tag = '0;
  logic [31:0] cpl_data = '0;
  logic        out_valid, out_ready = 1'b0, out_last;
  logic [31:0] out_data;
  logic        err_flag;

  int n_tests = 0, n_fail = 0;
  bit finished = 0;
  int exp_tag = 0;
  logic [32:0] exp_q[$];
  logic [31:0] pend_data [8][16];
  int pend_len [8];
  int pend_pos [8];
  int ready_pct = 75;

  always #2 clk = ~clk;

  cpl_reorder_buf dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready), .req_tag(req_tag),
    .cpl_valid(cpl_valid), .cpl_tag(cpl_tag), .cpl_data(cpl_data), .cpl_last(cpl_last),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
    .err_flag(err_flag)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  // consumer: random ready, checks each handshaken word against issue order
  initial begin
    logic        hold;
    logic [32:0] held;
    hold = 0;
    held = '0;
    forever begin
      @(negedge clk);
      if (hold && !rst) chk(out_valid && ({out_last, out_data} == held), "R6 hold", {out_valid, out_last, out_data}, {1'b1, held});
      out_ready = (($urandom % 100) < ready_pct);
      hold = 0;
      if (out_valid && !rst) begin
        if (out_ready) begin
          if (exp_q.size() == 0) chk(0, "R4 unexpected word", {out_last, out_data}, 0);
          else begin
            logic [32:0] e;
            e = exp_q.pop_front();
            chk({out_last, out_data} == e, "R3 R4 R7 word", {out_last, out_data}, e);
          end
        end else begin
          hold = 1;
          held = {out_last, out_data};
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    finish_run();
  end

  task automatic do_reset();
    @(negedge clk);
    rst = 1; req_valid = 0; cpl_valid = 0;
    exp_q.delete();
    exp_tag = 0;
    for (int t = 0; t < 8; t++) begin pend_len[t] = 0; pend_pos[t] = 0; end
    repeat (3) @(negedge clk);
    rst = 0;
  endtask

  task automatic issue(input int len, output int tag);
    forever begin
      @(negedge clk);
      if (req_ready) break;
    end
    chk(req_tag == 3'(exp_tag), "R1 tag order", req_tag, exp_tag);
    tag = exp_tag;
    exp_tag = (exp_tag + 1) % 8;
    pend_len[tag] = len;
    pend_pos[tag] = 0;
    for (int i = 0; i < len; i++) begin
      pend_data[tag][i] = $urandom;
      exp_q.push_back({(i == len - 1), pend_data[tag][i]});
    end
    req_valid = 1;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic beat_raw(input int tag, input logic [31:0] d, input bit last);
    @(negedge clk);
    cpl_valid = 1; cpl_tag = 3'(tag); cpl_data = d; cpl_last = last;
  endtask

  task automatic cpl_off();
    @(negedge clk);
    cpl_valid = 0; cpl_last = 0;
  endtask

  task automatic send_next(input int tag);
    int p;
    p = pend_pos[tag];
    beat_raw(tag, pend_data[tag][p], p == pend_len[tag] - 1);
    pend_pos[tag] = p + 1;
  endtask

  task automatic send_all(input int tag);
    while (pend_pos[tag] < pend_len[tag]) send_next(tag);
    cpl_off();
  endtask

  task automatic wait_drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    int tg;
    int tags[8];
    void'($urandom(32'd20240611));
    do_reset();
    @(negedge clk);
    // R10 reset state
    chk(req_ready == 1, "R10 req_ready", req_ready, 1);
    chk(req_tag == 0, "R10 req_tag", req_tag, 0);
    chk(out_valid == 0, "R10 out_valid", out_valid, 0);
    chk(err_flag == 0, "R10 err_flag", err_flag, 0);

    // R11 latency: beat at edge E, word valid after E+1
    issue(1, tg);
    beat_raw(tg, pend_data[tg][0], 1);
    pend_pos[tg] = 1;
    @(negedge clk);
    cpl_valid = 0;
    chk(out_valid == 0, "R11 not yet", out_valid, 0);
    @(negedge clk);
    chk(out_valid == 1, "R11 first word due", out_valid, 1);
    wait_drain();

    // R4 interleaved pieces, round robin
    for (int k = 0; k < 3; k++) issue(3, tags[k]);
    for (int p = 0; p < 3; p++)
      for (int k = 0; k < 3; k++) send_next(tags[k]);
    cpl_off();
    wait_drain();

    // R7 single-word and full-buffer reads, reverse completion order
    issue(16, tags[0]);
    issue(1, tags[1]);
    issue(16, tags[2]);
    send_all(tags[2]);
    send_all(tags[1]);
    send_all(tags[0]);
    wait_drain();

    // R2 and R5: fill all tags, complete younger ones first
    for (int k = 0; k < 8; k++) issue(1 + ($urandom % 4), tags[k]);
    @(negedge clk);
    chk(req_ready == 0, "R2 full stall", req_ready, 0);
    for (int k = 1; k < 8; k++) send_all(tags[k]);
    repeat (8) @(negedge clk);
    chk(out_valid == 0, "R5 waits for oldest", out_valid, 0);
    chk(exp_q.size() != 0, "R5 nothing drained", exp_q.size(), 1);
    send_all(tags[0]);
    wait_drain();
    chk(req_ready == 1, "R2 ready after drain", req_ready, 1);

    // random rounds, interleaved split completions
    for (int r = 0; r < 60; r++) begin
      int k;
      k = 1 + ($urandom % 8);
      for (int j = 0; j < k; j++) issue(1 + ($urandom % 16), tags[j]);
      forever begin
        int left, pick;
        left = 0;
        for (int j = 0; j < k; j++) if (pend_pos[tags[j]] < pend_len[tags[j]]) left++;
        if (left == 0) break;
        pick = $urandom % k;
        while (pend_pos[tags[pick]] >= pend_len[tags[pick]]) pick = (pick + 1) % k;
        send_next(tags[pick]);
        if (($urandom % 4) == 0) cpl_off();
      end
      cpl_off();
      if (($urandom % 3) == 0) ready_pct = 30; else ready_pct = 80;
      wait_drain();
    end
    ready_pct = 75;
    chk(err_flag == 0, "R8 no spurious error", err_flag, 0);

    // R9 beat after last is dropped
    do_reset();
    issue(2, tags[0]);
    issue(1, tags[1]);
    send_all(tags[1]);
    chk(err_flag == 0, "R9 before extra", err_flag, 0);
    beat_raw(tags[1], 32'hDEAD_BEEF, 1);
    @(negedge clk);
    cpl_valid = 0;
    chk(err_flag == 1, "R9 extra beat flagged", err_flag, 1);
    send_all(tags[0]);
    wait_drain();

    // R9 overflow beyond sixteen words
    do_reset();
    issue(16, tags[0]);
    for (int i = 0; i < 16; i++) beat_raw(tags[0], pend_data[tags[0]][i], 0);
    cpl_off();
    chk(err_flag == 0, "R9 sixteen fit", err_flag, 0);
    beat_raw(tags[0], 32'h1234_5678, 0);
    @(negedge clk);
    cpl_valid = 0;
    chk(err_flag == 1, "R9 overflow flagged", err_flag, 1);
    chk(out_valid == 0, "R9 no output", out_valid, 0);

    // R8 unallocated tag
    do_reset();
    beat_raw(5, 32'hCAFE_0005, 1);
    @(negedge clk);
    cpl_valid = 0;
    chk(err_flag == 1, "R8 unallocated flagged", err_flag, 1);
    repeat (6) @(negedge clk);
    chk(err_flag == 1, "R8 sticky", err_flag, 1);
    chk(out_valid == 0, "R8 dropped beat not output", out_valid, 0);
    issue(2, tags[0]);
    chk(tags[0] == 0, "R8 tag pool untouched", tags[0], 0);
    send_all(tags[0]);
    wait_drain();

    finish_run();
  end
endmodule